// File: doc/BRIEF.md
# Decode-Stage Stall Detector

This block sits beside the decode stage of a five-stage in-order pipeline. On every cycle it looks at three things: the operand class and the two source register numbers of the instruction being decoded, and the destination number, write enable and load flag of each of the two instructions ahead of it. The stage after decode is called EX here, and the stage after that is called MEM. The block finds the read-after-write dependences that the forwarding paths cannot satisfy in time. For each one it raises a stall that freezes the program counter and the fetch/decode register. In the same cycle it raises a bubble request that makes the pipeline load all-zero control into the decode/execute register.

Conditional branches and register jumps compare their operands or read their target in decode. Because of this, the cost of a dependence depends on two things: the kind of producer and how far ahead of the consumer it is. An arithmetic result needed in decode costs one bubble. A loaded value needed in decode costs two bubbles when the load is the instruction just ahead, and one bubble when the load is two instructions ahead. An operand that is needed in EX waits only for a load that is the instruction just ahead. The data register of a store is needed in MEM, so it never waits. The block is purely combinational, and its outputs follow its inputs within the same cycle.

Top module: `hz_stall_unit`

## Requirements
- R1: When the EX instruction is a load (load flag 1, write enable 1) whose nonzero destination equals a register that the decoding instruction reads in EX, stall_o is 1. Class codes that read in EX: 1 (rs only), 2 (rs and rt), 6 (rt only), and 3 (store, rs as base). With pipeline freeze this costs exactly one stall cycle.
- R2: A load followed by one unrelated instruction and then an EX-stage consumer of the loaded register causes no stall.
- R3: An arithmetic producer (write enable 1, load flag 0) in EX whose destination is read by a decode-resolved consumer causes exactly one stall cycle. Decode-resolved class codes are 4 (rs only, register jump) and 5 (rs and rt, branch compare).
- R4: A load immediately ahead of a dependent decode-resolved consumer causes exactly two consecutive stall cycles.
- R5: A load two instructions ahead of a dependent decode-resolved consumer causes exactly one stall cycle.
- R6: An arithmetic producer followed immediately by an EX-stage consumer causes no stall. An arithmetic producer two instructions ahead of a decode-resolved consumer also causes no stall.
- R7: A dependence through register 0 never causes a stall.
- R8: The data operand (rt) of a store (class 3) never stalls, even when a load immediately ahead writes it. The base operand (rs) stalls as in R1.
- R9: Source fields that the decoding class does not read have no effect. Class 0 reads no register. Class 1 ignores rt, and class 6 ignores rs.
- R10: bubble_o is 1 in exactly the cycles in which stall_o is 1, and both follow the inputs in the same cycle with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_kind_i | input | 3 | Operand class of the decoding instruction (codes in R1, R3, R8, R9) |
| dec_rs_i | input | 5 | First source register number of the decoding instruction |
| dec_rt_i | input | 5 | Second source register number of the decoding instruction |
| ex_dst_i | input | 5 | Destination register of the instruction in EX |
| ex_wen_i | input | 1 | Register write enable of the instruction in EX |
| ex_load_i | input | 1 | Instruction in EX is a load |
| mem_dst_i | input | 5 | Destination register of the instruction in MEM |
| mem_wen_i | input | 1 | Register write enable of the instruction in MEM |
| mem_load_i | input | 1 | Instruction in MEM is a load |
| stall_o | output | 1 | Freeze the program counter and the fetch/decode register |
| bubble_o | output | 1 | Load zero control into the decode/execute register |

## Verification
The hardest case to reach is the second stall cycle of a load that feeds a branch. In that cycle the load has moved to MEM, a bubble occupies EX, and the same branch is still waiting in decode. That state appears only if the previous stall really froze the front of the pipeline. The bench therefore does not drive the ports directly. It runs a behavioural pipeline that fetches from short instruction sequences, holds fetch/decode on each stall and inserts a zero bubble. It then checks the number of stall cycles each sequence produced, and it compares every cycle against an operand-readiness model.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Operand class of the instruction in decode
  typedef enum logic [2:0] {
    OPK_NONE     = 3'd0,
    OPK_EX_RS    = 3'd1,
    OPK_EX_RS_RT = 3'd2,
    OPK_STORE    = 3'd3,
    OPK_DEC_RS   = 3'd4,
    OPK_DEC_RSRT = 3'd5,
    OPK_EX_RT    = 3'd6,
    OPK_RSVD     = 3'd7
  } opk_e;

  // Stage in which a source operand must be valid
  typedef enum logic [1:0] {
    NEED_NONE = 2'd0,
    NEED_DEC  = 2'd1,
    NEED_EX   = 2'd2,
    NEED_MEM  = 2'd3
  } need_e;

endpackage

// File: rtl/hz_need_decode.sv
module hz_need_decode
  import hz_pkg::*;
(
  input  opk_e  kind_i,
  output need_e rs_need_o,
  output need_e rt_need_o
);

  always_comb begin
    rs_need_o = NEED_NONE;
    rt_need_o = NEED_NONE;
    unique case (kind_i)
      OPK_EX_RS:    rs_need_o = NEED_EX;
      OPK_EX_RS_RT: begin
        rs_need_o = NEED_EX;
        rt_need_o = NEED_EX;
      end
      OPK_STORE: begin
        rs_need_o = NEED_EX;
        rt_need_o = NEED_MEM;
      end
      OPK_DEC_RS:   rs_need_o = NEED_DEC;
      OPK_DEC_RSRT: begin
        rs_need_o = NEED_DEC;
        rt_need_o = NEED_DEC;
      end
      OPK_EX_RT:    rt_need_o = NEED_EX;
      default: begin
        rs_need_o = NEED_NONE;
        rt_need_o = NEED_NONE;
      end
    endcase
  end

endmodule

// File: rtl/hz_src_check.sv
module hz_src_check
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  need_e             need_i,
  input  logic [REG_AW-1:0] ex_dst_i,
  input  logic              ex_wen_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] mem_dst_i,
  input  logic              mem_wen_i,
  input  logic              mem_load_i,
  output logic              wait_o
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic src_live;
  logic hit_ex;
  logic hit_mem;

  always_comb begin
    src_live = (src_i != ZERO_REG);
    hit_ex   = src_live && ex_wen_i  && (ex_dst_i  == src_i);
    hit_mem  = src_live && mem_wen_i && (mem_dst_i == src_i);
    unique case (need_i)
      // value read in decode: any EX producer, or a load still in MEM
      NEED_DEC: wait_o = hit_ex || (hit_mem && mem_load_i);
      // value read in EX: only a load right ahead is late
      NEED_EX:  wait_o = hit_ex && ex_load_i;
      default:  wait_o = 1'b0;
    endcase
  end

  always_comb begin
    // R7
    zero_src_chk: assert (src_live || !wait_o);
    // R8
    mem_need_chk: assert (need_i != NEED_MEM || !wait_o);
  end

endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [2:0]        dec_kind_i,
  input  logic [REG_AW-1:0] dec_rs_i,
  input  logic [REG_AW-1:0] dec_rt_i,
  input  logic [REG_AW-1:0] ex_dst_i,
  input  logic              ex_wen_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] mem_dst_i,
  input  logic              mem_wen_i,
  input  logic              mem_load_i,
  output logic              stall_o,
  output logic              bubble_o
);

  localparam int NSRC = 2;

  opk_e              kind;
  need_e             need [NSRC];
  logic [REG_AW-1:0] src  [NSRC];
  logic [NSRC-1:0]   src_wait;
  logic              hold;

  assign kind   = opk_e'(dec_kind_i);
  assign src[0] = dec_rs_i;
  assign src[1] = dec_rt_i;

  hz_need_decode u_need (
    .kind_i    (kind),
    .rs_need_o (need[0]),
    .rt_need_o (need[1])
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_src_check #(.REG_AW(REG_AW)) u_chk (
      .src_i      (src[g]),
      .need_i     (need[g]),
      .ex_dst_i   (ex_dst_i),
      .ex_wen_i   (ex_wen_i),
      .ex_load_i  (ex_load_i),
      .mem_dst_i  (mem_dst_i),
      .mem_wen_i  (mem_wen_i),
      .mem_load_i (mem_load_i),
      .wait_o     (src_wait[g])
    );
  end

  assign hold     = |src_wait;
  assign stall_o  = hold;
  assign bubble_o = hold;

  always_comb begin
    // R9
    no_read_chk: assert (kind != OPK_NONE || !stall_o);
    // R1
    load_use_chk: assert (!(ex_load_i && ex_wen_i && ex_dst_i != '0 &&
                           kind == OPK_EX_RS && dec_rs_i == ex_dst_i) || stall_o);
    // R4
    load_branch_chk: assert (!(mem_load_i && mem_wen_i && mem_dst_i != '0 &&
                              kind == OPK_DEC_RS && dec_rs_i == mem_dst_i) || stall_o);
    // R3
    alu_branch_chk: assert (!(ex_wen_i && ex_dst_i != '0 && kind == OPK_DEC_RSRT &&
                             dec_rt_i == ex_dst_i) || stall_o);
    // R6
    no_producer_chk: assert (ex_wen_i || mem_wen_i || !stall_o);
  end

endmodule

// File: tb/test_hz_stall_unit.sv
module test_hz_stall_unit;

  typedef struct {
    int kind;
    int rs;
    int rt;
    int dst;
    bit wen;
    bit ld;
    int scen;
  } instr_t;

  logic clk;
  logic rst_n;
  int   n_chk;
  int   n_fail;

  instr_t prog[$];
  instr_t ifid, idex, exmem;
  int     exp_cnt[$];
  string  exp_req[$];
  int     got_cnt[$];

  logic [2:0] dec_kind;
  logic [4:0] dec_rs, dec_rt, ex_dst, mem_dst;
  logic       ex_wen, ex_load, mem_wen, mem_load;
  logic       stall_o, bubble_o;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign dec_kind = 3'(ifid.kind);
  assign dec_rs   = 5'(ifid.rs);
  assign dec_rt   = 5'(ifid.rt);
  assign ex_dst   = 5'(idex.dst);
  assign ex_wen   = idex.wen;
  assign ex_load  = idex.ld;
  assign mem_dst  = 5'(exmem.dst);
  assign mem_wen  = exmem.wen;
  assign mem_load = exmem.ld;

  hz_stall_unit i_hz_stall_unit (
    .dec_kind_i (dec_kind),
    .dec_rs_i   (dec_rs),
    .dec_rt_i   (dec_rt),
    .ex_dst_i   (ex_dst),
    .ex_wen_i   (ex_wen),
    .ex_load_i  (ex_load),
    .mem_dst_i  (mem_dst),
    .mem_wen_i  (mem_wen),
    .mem_load_i (mem_load),
    .stall_o    (stall_o),
    .bubble_o   (bubble_o)
  );

  function automatic instr_t mk(int k, int s, int t, int d, bit w, bit l, int sc);
    instr_t r;
    r.kind = k; r.rs = s; r.rt = t; r.dst = d; r.wen = w; r.ld = l; r.scen = sc;
    return r;
  endfunction

  function automatic instr_t nop();
    return mk(0, 0, 0, 0, 1'b0, 1'b0, -1);
  endfunction

  // cycles from now until the register value can be picked up at stage 'need'
  // need: 1 = decode, 2 = execute, 3 = memory
  function automatic int late_by(int r, int need);
    int lat;
    lat = 0;
    if (r == 0 || need == 0) return 0;
    if (idex.wen && idex.dst == r) begin
      if (idex.ld) lat = (need == 1) ? 2 : ((need == 2) ? 1 : 0);
      else         lat = (need == 1) ? 1 : 0;
    end else if (exmem.wen && exmem.dst == r && exmem.ld && need == 1) begin
      lat = 1;
    end
    return lat;
  endfunction

  function automatic bit ref_stall();
    int nrs, nrt;
    case (ifid.kind)
      1: begin nrs = 2; nrt = 0; end
      2: begin nrs = 2; nrt = 2; end
      3: begin nrs = 2; nrt = 3; end
      4: begin nrs = 1; nrt = 0; end
      5: begin nrs = 1; nrt = 1; end
      6: begin nrs = 0; nrt = 2; end
      default: begin nrs = 0; nrt = 0; end
    endcase
    return (late_by(ifid.rs, nrs) > 0) || (late_by(ifid.rt, nrt) > 0);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic scen(string req, int exp);
    exp_req.push_back(req);
    exp_cnt.push_back(exp);
    got_cnt.push_back(0);
  endtask

  task automatic add(instr_t i);
    prog.push_back(i);
  endtask

  task automatic pad();
    for (int k = 0; k < 3; k++) prog.push_back(nop());
  endtask

  // kind codes: 1 ex rs, 2 ex rs+rt, 3 store, 4 jump reg, 5 branch, 6 ex rt
  task automatic build();
    int s;
    s = 0; scen("R6", 0);                                   // alu -> alu
    add(mk(2, 5, 6, 4, 1, 0, s)); add(mk(2, 4, 4, 7, 1, 0, s)); pad();
    s = 1; scen("R1", 1);                                   // load -> alu rt
    add(mk(1, 4, 0, 8, 1, 1, s)); add(mk(2, 9, 8, 10, 1, 0, s)); pad();
    s = 2; scen("R2", 0);                                   // load, gap, use
    add(mk(1, 4, 0, 8, 1, 1, s)); add(mk(2, 5, 6, 4, 1, 0, s));
    add(mk(2, 9, 8, 10, 1, 0, s)); pad();
    s = 3; scen("R3", 1);                                   // alu -> branch
    add(mk(2, 5, 6, 4, 1, 0, s)); add(mk(5, 0, 4, 0, 0, 0, s)); pad();
    s = 4; scen("R4", 2);                                   // load -> branch
    add(mk(1, 0, 0, 10, 1, 1, s)); add(mk(5, 0, 10, 0, 0, 0, s)); pad();
    s = 5; scen("R5", 1);                                   // load, gap, branch
    add(mk(1, 0, 0, 10, 1, 1, s)); add(mk(2, 5, 6, 4, 1, 0, s));
    add(mk(5, 0, 10, 0, 0, 0, s)); pad();
    s = 6; scen("R6", 0);                                   // alu, gap, branch
    add(mk(2, 5, 6, 4, 1, 0, s)); add(mk(2, 9, 10, 8, 1, 0, s));
    add(mk(5, 0, 4, 0, 0, 0, s)); pad();
    s = 7; scen("R8", 0);                                   // load -> store data
    add(mk(1, 0, 0, 4, 1, 1, s)); add(mk(3, 0, 4, 0, 0, 0, s)); pad();
    s = 8; scen("R8", 1);                                   // load -> store base
    add(mk(1, 0, 0, 4, 1, 1, s)); add(mk(3, 4, 5, 0, 0, 0, s)); pad();
    s = 9; scen("R7", 0);                                   // load r0 -> use r0
    add(mk(1, 4, 0, 0, 1, 1, s)); add(mk(2, 0, 0, 7, 1, 0, s)); pad();
    s = 10; scen("R7", 0);                                  // load r0 -> jr r0
    add(mk(1, 4, 0, 0, 1, 1, s)); add(mk(4, 0, 0, 0, 0, 0, s)); pad();
    s = 11; scen("R4", 2);                                  // load -> jr
    add(mk(1, 0, 0, 10, 1, 1, s)); add(mk(4, 10, 0, 0, 0, 0, s)); pad();
    s = 12; scen("R1", 1);                                  // load -> shift rt
    add(mk(1, 0, 0, 6, 1, 1, s)); add(mk(6, 0, 6, 7, 1, 0, s)); pad();
    s = 13; scen("R9", 0);                                  // load -> no-read
    add(mk(1, 0, 0, 6, 1, 1, s)); add(mk(0, 6, 6, 0, 0, 0, s)); pad();
    s = 14; scen("R9", 0);                                  // load -> rs-only, rt hit
    add(mk(1, 0, 0, 6, 1, 1, s)); add(mk(1, 2, 6, 7, 1, 0, s)); pad();
    s = 15; scen("R9", 0);                                  // load -> rt-only, rs hit
    add(mk(1, 0, 0, 6, 1, 1, s)); add(mk(6, 6, 2, 7, 1, 0, s)); pad();
    s = 16; scen("R1", 1);                                  // load -> rs-only consumer
    add(mk(1, 0, 0, 3, 1, 1, s)); add(mk(1, 3, 0, 9, 1, 0, s)); pad();
  endtask

  int pc;
  int cyc;
  bit exp_s;

  initial begin
    n_chk = 0; n_fail = 0; pc = 0; cyc = 0;
    ifid = nop(); idex = nop(); exmem = nop();
    rst_n = 1'b0;
    build();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(stall_o == 1'b0, "R7 reset", int'(stall_o), 0);
    check(bubble_o == 1'b0, "R10 reset", int'(bubble_o), 0);
    while (pc < prog.size() || ifid.scen >= 0 || idex.wen || exmem.wen) begin
      @(negedge clk);
      cyc++;
      if (cyc > 5000) begin
        check(1'b0, "watchdog", cyc, 0);
        break;
      end
      exp_s = ref_stall();
      check(stall_o == exp_s, "R1-model stall", int'(stall_o), int'(exp_s));
      check(bubble_o == stall_o, "R10 bubble", int'(bubble_o), int'(stall_o));
      if (stall_o && ifid.scen >= 0) got_cnt[ifid.scen]++;
      @(posedge clk);
      exmem = idex;
      if (stall_o) begin
        idex = nop();
      end else begin
        idex = ifid;
        ifid = (pc < prog.size()) ? prog[pc] : nop();
        pc++;
      end
    end
    foreach (exp_cnt[k])
      check(got_cnt[k] == exp_cnt[k], exp_req[k], got_cnt[k], exp_cnt[k]);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule